// File: doc/BRIEF.md
# Thresholded Energy and Missing-Energy Summer

This block takes a frame of 32 jet-element energies on every bunch-clock tick. The elements are laid out as 8 azimuth bins by 4 rows. Each element is compared against a threshold, and the elements that pass feed two parallel results. The first is a scalar transverse-energy sum. The second is a missing-energy vector: each azimuth bin's passing energy is weighted by the fixed cosine and sine of that bin's angle.

Two separate thresholds gate the two paths, so a low-energy element can count toward the scalar sum while being excluded from the vector. Saturation is carried through every pipeline stage. A saturated input, or a sum that exceeds the output range, forces the result to a clamp value. The block is a fixed four-tick pipeline, and a valid strobe travels alongside the data.

Top module: `jetsum_top`

## Requirements
- R1: While reset is asserted and after its release, `outValid` is 0 and `etSum`, `exSum` and `eySum` are all 0 until the first result arrives.
- R2: A frame presented with `inValid`=1 at one rising edge appears on the outputs with `outValid`=1 exactly four rising edges later. Frames on consecutive ticks emerge on consecutive ticks.
- R3: Element index i = row*8 + bin occupies `jetElems[i*10 +: 10]`. The scalar sum `etSum` is the plain sum of every element whose value is greater than or equal to `etThresh`.
- R4: An element below a path's threshold contributes nothing to that path. `etThresh` gates only the scalar path and `vecThresh` gates only the vector path.
- R5: When the scalar sum exceeds 4095, `etSum` is 4095.
- R6: An element of value 1023 (the saturated code) that passes `etThresh` forces `etSum` to 4095.
- R7: For each bin b, let V(b) be the sum of that bin's elements that are at least `vecThresh`. The cosine coefficients for b = 0..7 are 256, 181, 0, -181, -256, -181, 0, 181, and the sine coefficient for bin b is the cosine coefficient for bin (b+6) mod 8. Each bin adds floor(V(b)*coef/64) to its component, and `exSum`/`eySum` are the two's-complement sums in 0.25 GeV units.
- R8: A vector component whose sum is above 8191 outputs 8191, and one whose sum is below -8192 outputs -8192.
- R9: An element of value 1023 that passes `vecThresh` forces both `exSum` and `eySum` to 8191.
- R10: While no frame reaches the output stage, `outValid` is 0 and the three sums hold their last values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Frame on `jetElems` is valid this tick |
| jetElems | input | 320 | 32 unsigned 10-bit jet elements, index row*8+bin |
| etThresh | input | 10 | Scalar-path threshold |
| vecThresh | input | 10 | Vector-path threshold |
| outValid | output | 1 | Sums belong to a frame |
| etSum | output | 12 | Scalar transverse energy, 1 GeV per count |
| exSum | output | 14 | Signed x component, 0.25 GeV per count |
| eySum | output | 14 | Signed y component, 0.25 GeV per count |

## Verification
The first stimulus is a single element placed in different bins and rows. This separates the index-to-bin mapping, the sign of every coefficient and the floor rounding of negative terms. Uniform full frames make opposing bins cancel, while the scalar sum saturates. Energy concentrated in one bin drives each vector component to its positive and its negative clamp independently. A saturated code placed below and above each threshold shows whether the saturation flag obeys the threshold. Pseudo-random frames streamed on consecutive ticks check latency alignment against the arithmetic model, and idle ticks with changing inputs show that the outputs hold.

// File: rtl/jetsum_pkg.sv
package jetsum_pkg;

  localparam int N_BINS    = 8;
  localparam int COEF_W    = 10;
  localparam int COEF_FRAC = 8;
  localparam int OUT_FRAC  = 2;
  localparam int TERM_SHIFT = COEF_FRAC - OUT_FRAC;

  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } stageStb_t;

  function automatic logic signed [COEF_W-1:0] cosCoef(input int bin);
    case (bin % N_BINS)
      0:       return 10'sd256;
      1:       return 10'sd181;
      2:       return 10'sd0;
      3:       return -10'sd181;
      4:       return -10'sd256;
      5:       return -10'sd181;
      6:       return 10'sd0;
      default: return 10'sd181;
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] sinCoef(input int bin);
    return cosCoef((bin + 6) % N_BINS);
  endfunction

endpackage

// File: rtl/jetsum_ctrl.sv
module jetsum_ctrl
  import jetsum_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output stageStb_t stb,
  output logic      outValid
);

  logic [2:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      outValid  <= 1'b0;
    end else begin
      validPipe <= {validPipe[1:0], inValid};
      outValid  <= validPipe[2];
    end
  end

  always_comb begin
    stb.s1 = inValid;
    stb.s2 = validPipe[0];
    stb.s3 = validPipe[1];
    stb.s4 = validPipe[2];
  end

endmodule

// File: rtl/jetsum_datapath.sv
module jetsum_datapath
  import jetsum_pkg::*;
#(
  parameter int ELEM_W = 10,
  parameter int N_ROWS = 4,
  parameter int ET_W   = 12,
  parameter int VEC_W  = 14
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  stageStb_t                         stb,
  input  logic [N_ROWS*N_BINS*ELEM_W-1:0]   jetElems,
  input  logic [ELEM_W-1:0]                 etThresh,
  input  logic [ELEM_W-1:0]                 vecThresh,
  output logic [ET_W-1:0]                   etSum,
  output logic signed [VEC_W-1:0]           exSum,
  output logic signed [VEC_W-1:0]           eySum
);

  localparam int N_ELEMS = N_ROWS * N_BINS;
  localparam int BIN_W   = ELEM_W + $clog2(N_ROWS);
  localparam int PROD_W  = BIN_W + 1 + COEF_W;
  localparam int ACC_W   = PROD_W + $clog2(N_BINS);
  localparam int ETT_W   = BIN_W + $clog2(N_BINS);
  localparam logic [ETT_W-1:0] ET_MAX = ETT_W'((2 ** ET_W) - 1);
  localparam logic signed [ACC_W-1:0] V_MAX = ACC_W'((2 ** (VEC_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] V_MIN = -V_MAX - 1;

  // Stage 1: threshold gating and saturation detection
  logic [ELEM_W-1:0] etElemD  [N_ELEMS];
  logic [ELEM_W-1:0] vecElemD [N_ELEMS];
  logic [N_ELEMS-1:0] etSatV, vecSatV;
  logic [ELEM_W-1:0] etElemR  [N_ELEMS];
  logic [ELEM_W-1:0] vecElemR [N_ELEMS];
  logic etSat1, vecSat1;

  for (genvar i = 0; i < N_ELEMS; i++) begin : g_elem
    logic [ELEM_W-1:0] e;
    assign e           = jetElems[i*ELEM_W +: ELEM_W];
    assign etElemD[i]  = (e >= etThresh)  ? e : '0;
    assign vecElemD[i] = (e >= vecThresh) ? e : '0;
    assign etSatV[i]   = (e >= etThresh)  && (&e);
    assign vecSatV[i]  = (e >= vecThresh) && (&e);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_ELEMS; i++) begin
        etElemR[i]  <= '0;
        vecElemR[i] <= '0;
      end
      etSat1  <= 1'b0;
      vecSat1 <= 1'b0;
    end else if (stb.s1) begin
      for (int i = 0; i < N_ELEMS; i++) begin
        etElemR[i]  <= etElemD[i];
        vecElemR[i] <= vecElemD[i];
      end
      etSat1  <= |etSatV;
      vecSat1 <= |vecSatV;
    end
  end

  // Stage 2: per-bin sums over the rows
  logic [BIN_W-1:0] etBinD  [N_BINS];
  logic [BIN_W-1:0] vecBinD [N_BINS];
  logic [BIN_W-1:0] etBinR  [N_BINS];
  logic [BIN_W-1:0] vecBinR [N_BINS];
  logic etSat2, vecSat2;

  for (genvar b = 0; b < N_BINS; b++) begin : g_bin
    always_comb begin
      etBinD[b]  = '0;
      vecBinD[b] = '0;
      for (int r = 0; r < N_ROWS; r++) begin
        etBinD[b]  = etBinD[b]  + BIN_W'(etElemR[r*N_BINS + b]);
        vecBinD[b] = vecBinD[b] + BIN_W'(vecElemR[r*N_BINS + b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < N_BINS; b++) begin
        etBinR[b]  <= '0;
        vecBinR[b] <= '0;
      end
      etSat2  <= 1'b0;
      vecSat2 <= 1'b0;
    end else if (stb.s2) begin
      for (int b = 0; b < N_BINS; b++) begin
        etBinR[b]  <= etBinD[b];
        vecBinR[b] <= vecBinD[b];
      end
      etSat2  <= etSat1;
      vecSat2 <= vecSat1;
    end
  end

  // Stage 3: trig weighting per bin, scalar total
  logic signed [PROD_W-1:0] xTermD [N_BINS];
  logic signed [PROD_W-1:0] yTermD [N_BINS];
  logic signed [PROD_W-1:0] xTermR [N_BINS];
  logic signed [PROD_W-1:0] yTermR [N_BINS];
  logic [ETT_W-1:0] etTotD, etTotR;
  logic etSat3, vecSat3;

  for (genvar b = 0; b < N_BINS; b++) begin : g_term
    logic signed [BIN_W:0]    binS;
    logic signed [PROD_W-1:0] xProd, yProd;
    assign binS      = $signed({1'b0, vecBinR[b]});
    assign xProd     = binS * cosCoef(b);
    assign yProd     = binS * sinCoef(b);
    assign xTermD[b] = xProd >>> TERM_SHIFT;
    assign yTermD[b] = yProd >>> TERM_SHIFT;
  end

  always_comb begin
    etTotD = '0;
    for (int b = 0; b < N_BINS; b++) etTotD = etTotD + ETT_W'(etBinR[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < N_BINS; b++) begin
        xTermR[b] <= '0;
        yTermR[b] <= '0;
      end
      etTotR  <= '0;
      etSat3  <= 1'b0;
      vecSat3 <= 1'b0;
    end else if (stb.s3) begin
      for (int b = 0; b < N_BINS; b++) begin
        xTermR[b] <= xTermD[b];
        yTermR[b] <= yTermD[b];
      end
      etTotR  <= etTotD;
      etSat3  <= etSat2;
      vecSat3 <= vecSat2;
    end
  end

  // Stage 4: vector accumulation and clamping
  logic signed [ACC_W-1:0] xAcc, yAcc;
  logic [ET_W-1:0]         etClamp;
  logic signed [VEC_W-1:0] xClamp, yClamp;

  always_comb begin
    xAcc = '0;
    yAcc = '0;
    for (int b = 0; b < N_BINS; b++) begin
      xAcc = xAcc + {{(ACC_W-PROD_W){xTermR[b][PROD_W-1]}}, xTermR[b]};
      yAcc = yAcc + {{(ACC_W-PROD_W){yTermR[b][PROD_W-1]}}, yTermR[b]};
    end
    if (etSat3 || (etTotR > ET_MAX)) etClamp = ET_MAX[ET_W-1:0];
    else                             etClamp = etTotR[ET_W-1:0];
    if (vecSat3 || (xAcc > V_MAX)) xClamp = V_MAX[VEC_W-1:0];
    else if (xAcc < V_MIN)         xClamp = V_MIN[VEC_W-1:0];
    else                           xClamp = xAcc[VEC_W-1:0];
    if (vecSat3 || (yAcc > V_MAX)) yClamp = V_MAX[VEC_W-1:0];
    else if (yAcc < V_MIN)         yClamp = V_MIN[VEC_W-1:0];
    else                           yClamp = yAcc[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      etSum <= '0;
      exSum <= '0;
      eySum <= '0;
    end else if (stb.s4) begin
      etSum <= etClamp;
      exSum <= xClamp;
      eySum <= yClamp;
    end
  end

endmodule

// File: rtl/jetsum_top.sv
module jetsum_top
  import jetsum_pkg::*;
#(
  parameter int ELEM_W = 10,
  parameter int N_ROWS = 4,
  parameter int ET_W   = 12,
  parameter int VEC_W  = 14
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [N_ROWS*N_BINS*ELEM_W-1:0] jetElems,
  input  logic [ELEM_W-1:0]               etThresh,
  input  logic [ELEM_W-1:0]               vecThresh,
  output logic                            outValid,
  output logic [ET_W-1:0]                 etSum,
  output logic signed [VEC_W-1:0]         exSum,
  output logic signed [VEC_W-1:0]         eySum
);

  stageStb_t stb;

  jetsum_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  jetsum_datapath #(
    .ELEM_W (ELEM_W),
    .N_ROWS (N_ROWS),
    .ET_W   (ET_W),
    .VEC_W  (VEC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .jetElems  (jetElems),
    .etThresh  (etThresh),
    .vecThresh (vecThresh),
    .etSum     (etSum),
    .exSum     (exSum),
    .eySum     (eySum)
  );

endmodule

// File: rtl/jetsum_checker.sv
module jetsum_checker
  import jetsum_pkg::*;
#(
  parameter int ELEM_W = 10,
  parameter int N_ROWS = 4,
  parameter int ET_W   = 12,
  parameter int VEC_W  = 14
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            inValid,
  input logic [N_ROWS*N_BINS*ELEM_W-1:0] jetElems,
  input logic                            outValid,
  input logic [ET_W-1:0]                 etSum,
  input logic signed [VEC_W-1:0]         exSum,
  input logic signed [VEC_W-1:0]         eySum,
  input stageStb_t                       stb
);

  localparam int N_ELEMS = N_ROWS * N_BINS;

  logic [2:0] sinceReset;
  logic       satAny, allZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 3'd7) sinceReset <= sinceReset + 3'd1;
  end

  always_comb begin
    satAny  = 1'b0;
    allZero = 1'b1;
    for (int i = 0; i < N_ELEMS; i++) begin
      if (&jetElems[i*ELEM_W +: ELEM_W]) satAny = 1'b1;
      if (|jetElems[i*ELEM_W +: ELEM_W]) allZero = 1'b0;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 3'd4) |-> (outValid == $past(inValid, 4)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.s4 |=> ($stable(etSum) && $stable(exSum) && $stable(eySum) && !outValid));

  // R6
  sat_et_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceReset >= 3'd4) && $past(inValid && satAny, 4)) |-> (etSum == {ET_W{1'b1}}));

  // R3
  zero_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceReset >= 3'd4) && $past(inValid && allZero, 4))
      |-> (etSum == '0 && exSum == '0 && eySum == '0));

endmodule

bind jetsum_top jetsum_checker #(
  .ELEM_W (ELEM_W),
  .N_ROWS (N_ROWS),
  .ET_W   (ET_W),
  .VEC_W  (VEC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .jetElems (jetElems),
  .outValid (outValid),
  .etSum    (etSum),
  .exSum    (exSum),
  .eySum    (eySum),
  .stb      (stb)
);

// File: tb/sim_jetsum_top.sv
module sim_jetsum_top;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [NE*10-1:0]  jetElems = '0;
  logic [9:0]        etThresh = '0;
  logic [9:0]        vecThresh = '0;
  logic              outValid;
  logic [11:0]       etSum;
  logic signed [13:0] exSum, eySum;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  jetsum_top u0 (
    .clk (clk), .rstN (rstN), .inValid (inValid), .jetElems (jetElems),
    .etThresh (etThresh), .vecThresh (vecThresh), .outValid (outValid),
    .etSum (etSum), .exSum (exSum), .eySum (eySum)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cosT(input int b);
    int t[8] = '{256, 181, 0, -181, -256, -181, 0, 181};
    return t[b % 8];
  endfunction

  function automatic void model(input logic [NE*10-1:0] el, input int te, input int tv,
                                output int et, output int ex, output int ey);
    int binV[8];
    int tot = 0;
    bit sE = 0, sV = 0;
    for (int b = 0; b < 8; b++) binV[b] = 0;
    for (int i = 0; i < NE; i++) begin
      int e = int'(el[i*10 +: 10]);
      if (e >= te) begin tot += e; if (e == 1023) sE = 1; end
      if (e >= tv) begin binV[i % 8] += e; if (e == 1023) sV = 1; end
    end
    et = (sE || tot > 4095) ? 4095 : tot;
    ex = 0; ey = 0;
    for (int b = 0; b < 8; b++) begin
      ex += (binV[b] * cosT(b)) >>> 6;
      ey += (binV[b] * cosT(b + 6)) >>> 6;
    end
    if (ex > 8191) ex = 8191; else if (ex < -8192) ex = -8192;
    if (ey > 8191) ey = 8191; else if (ey < -8192) ey = -8192;
    if (sV) begin ex = 8191; ey = 8191; end
  endfunction

  function automatic logic [9:0] nextRand(input logic [9:0] mask);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[9:0] & mask;
  endfunction

  task automatic checkOut(input string req, input logic [NE*10-1:0] el, input int te, input int tv);
    int et, ex, ey;
    model(el, te, tv, et, ex, ey);
    chk({req, " outValid"}, int'(outValid), 1);
    chk({req, " etSum"}, int'(etSum), et);
    chk({req, " exSum"}, int'(exSum), ex);
    chk({req, " eySum"}, int'(eySum), ey);
  endtask

  // Drive one frame at a negedge, check latency and values.
  task automatic runFrame(input string req, input logic [NE*10-1:0] el, input int te, input int tv);
    jetElems = el; etThresh = 10'(te); vecThresh = 10'(tv); inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({req, " R2 not early"}, int'(outValid), 0);
    @(posedge clk);
    @(negedge clk);
    checkOut(req, el, te, tv);
  endtask

  function automatic logic [NE*10-1:0] oneElem(input int idx, input int val);
    logic [NE*10-1:0] v = '0;
    v[idx*10 +: 10] = 10'(val);
    return v;
  endfunction

  task automatic testReset();
    @(negedge clk);
    chk("R1 outValid in reset", int'(outValid), 0);
    chk("R1 etSum in reset", int'(etSum), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 exSum after reset", int'(exSum), 0);
    chk("R1 eySum after reset", int'(eySum), 0);
  endtask

  task automatic testSingles();
    runFrame("R3 R7 bin0 row0", oneElem(0, 100), 0, 0);
    runFrame("R3 R7 bin3 row2", oneElem(19, 77), 0, 0);
    runFrame("R3 R7 bin6 row3", oneElem(30, 333), 0, 0);
    runFrame("R3 R7 bin5 row1", oneElem(13, 5), 0, 0);
  endtask

  task automatic testThresholds();
    logic [NE*10-1:0] v = '0;
    for (int i = 0; i < NE; i++) v[i*10 +: 10] = 10'(i * 13);
    runFrame("R4 split thresholds", v, 150, 300);
    runFrame("R4 et below thresh", oneElem(4, 40), 41, 0);
    runFrame("R4 vec below thresh", oneElem(4, 40), 0, 41);
    runFrame("R4 at threshold", oneElem(9, 41), 41, 41);
  endtask

  task automatic testOverflow();
    logic [NE*10-1:0] v = '0;
    for (int i = 0; i < NE; i++) v[i*10 +: 10] = 10'd500;
    runFrame("R5 scalar clamp", v, 0, 0);
    v = '0;
    for (int r = 0; r < 4; r++) v[(r*8 + 0)*10 +: 10] = 10'd1000;
    runFrame("R8 x positive clamp", v, 0, 0);
    chk("R8 ex at +8191", int'(exSum), 8191);
    v = '0;
    for (int r = 0; r < 4; r++) v[(r*8 + 4)*10 +: 10] = 10'd1000;
    runFrame("R8 x negative clamp", v, 0, 0);
    chk("R8 ex at -8192", int'(exSum), -8192);
    v = '0;
    for (int r = 0; r < 4; r++) v[(r*8 + 6)*10 +: 10] = 10'd900;
    runFrame("R8 y negative clamp", v, 0, 0);
    chk("R8 ey at -8192", int'(eySum), -8192);
  endtask

  task automatic testSaturated();
    runFrame("R6 R9 saturated bin5", oneElem(21, 1023), 0, 0);
    chk("R6 et forced", int'(etSum), 4095);
    chk("R9 ex forced", int'(exSum), 8191);
    runFrame("R6 R9 saturated thresholds high", oneElem(2, 1023), 1023, 1023);
  endtask

  task automatic testHold();
    int et0, ex0, ey0;
    runFrame("R10 setup", oneElem(11, 222), 0, 0);
    et0 = int'(etSum); ex0 = int'(exSum); ey0 = int'(eySum);
    for (int k = 0; k < 6; k++) begin
      jetElems = {NE{nextRand(10'h3FF)}};
      etThresh = nextRand(10'h0FF);
      @(negedge clk);
      chk("R10 outValid idle", int'(outValid), 0);
      chk("R10 etSum held", int'(etSum), et0);
      chk("R10 exSum held", int'(exSum), ex0);
      chk("R10 eySum held", int'(eySum), ey0);
    end
  endtask

  task automatic testStream();
    logic [NE*10-1:0] fr[3];
    int te[3], tv[3];
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < NE; i++) fr[f][i*10 +: 10] = nextRand(10'h1FF);
      te[f] = int'(nextRand(10'h07F));
      tv[f] = int'(nextRand(10'h0FF));
    end
    for (int f = 0; f < 3; f++) begin
      jetElems = fr[f]; etThresh = 10'(te[f]); vecThresh = 10'(tv[f]); inValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      checkOut("R2 R7 streamed frame", fr[f], te[f], tv[f]);
      @(negedge clk);
    end
    chk("R2 stream ends", int'(outValid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testSingles();
    testThresholds();
    testOverflow();
    testSaturated();
    testHold();
    testStream();
    testStream();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule